// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation conversion. A rising edge on a start request begins a conversion. The block then tracks the input for a fixed number of falling edges of a free-running conversion clock. It asserts a hold control and searches the code space one bit per falling edge, from the most significant bit down. The trial code drives an external ladder and comparator. The comparator answers with a single bit: the input is at or above the trial. The answer for the LSB ends the search. In the next cycle the final code goes into a separate result latch, the done flag rises, and the search register clears for the next conversion.

Everything runs on one system clock. The conversion clock and the start request arrive as plain levels, and the block samples them. A falling edge of the conversion clock is counted only after the start has been registered for a minimum setup interval. An edge that comes too soon after the start is skipped, so counting begins one conversion-clock period later. The result is a held latch, not a stream. It has no valid/ready handshake and never applies back-pressure. The done flag stays high and the result stays unchanged until the next accepted start, so a consumer may read them at any time.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, hold_o, busy_o and done_o are low, and trial_o and result_o are 00h.
- R2: A rising edge of start_i seen while idle is accepted. busy_o rises and done_o clears in the same clock edge that samples the start.
- R3: After a start is accepted, a falling edge of cclk_i counts only if it is sampled at least SETUP_CYCLES+1 clock edges after the accepting edge. An earlier falling edge is skipped. With SETUP_CYCLES=1 and a 10-cycle conversion clock, a start whose first falling edge is sampled one edge later than the accepting edge takes exactly 9 cycles longer than one whose first falling edge is sampled two edges later.
- R4: On the HOLD_EDGES-th (default 4) counted falling edge, hold_o rises and trial_o becomes 80h (only the MSB set).
- R5: On each later falling edge, one bit is decided. The current trial bit stays set if cmp_ge_i is 1 and is cleared otherwise. The next lower bit is then set. trial_o does not change between falling edges.
- R6: One cycle after the LSB decision, result_o takes the final code and done_o rises. In the same edge hold_o and busy_o fall and trial_o returns to 00h.
- R7: The result is offset binary. An input code of 00h, 80h or FFh, compared by an ideal comparator, gives that same result.
- R8: A start edge that arrives while a conversion is in progress is ignored. The conversion runs on unchanged and gives the same result and latency.
- R9: result_o keeps the previous result until the transfer of the new one.
- R10: With the conversion clock in a fixed phase relative to the start, the latency from the accepting edge to done_o is the same for every conversion: 113 clock cycles for a 10-cycle conversion clock whose first falling edge qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request; its rising edge starts a conversion |
| cclk_i | input | 1 | Free-running conversion clock level, sampled on clk |
| cmp_ge_i | input | 1 | Comparator answer: 1 when the input is at or above trial_o |
| hold_o | output | 1 | Track/hold control: 0 tracks, 1 holds |
| trial_o | output | 8 | Trial code for the ladder |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result available; cleared by the next accepted start |
| result_o | output | 8 | Latched result of the last conversion |

## Verification
The assertions assume that cmp_ge_i depends only on the current trial code and a constant input for the whole conversion. They also assume that cclk_i stays at each level for at least one clock cycle, so that every falling edge shows up as a single-cycle event. The bench holds its stimulus code fixed during each conversion and computes the comparator answer directly from trial_o. It derives the conversion clock from a divide-by-ten counter with equal high and low halves. Start requests are placed at chosen phases of that counter, so both the qualifying case and the skipped-edge case of the setup window occur on purpose.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TRACK = 2'd1,
    SEQ_CONV  = 2'd2,
    SEQ_XFER  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/sar_edge_qual.sv
module sar_edge_qual #(
  parameter int SETUP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cclk_i,
  input  logic track_i,
  output logic start_rise_o,
  output logic cclk_fall_o,
  output logic fall_ok_o
);

  localparam int SW = (SETUP_CYCLES > 0) ? $clog2(SETUP_CYCLES + 1) : 1;
  localparam logic [SW-1:0] SETUP_MAX = SW'(SETUP_CYCLES);

  logic          start_q;
  logic          cclk_q;
  logic [SW-1:0] setup_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cclk_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      cclk_q  <= cclk_i;
    end
  end

  // Counts the cycles spent tracking; saturates once the setup interval is met.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cnt <= '0;
    end else if (!track_i) begin
      setup_cnt <= '0;
    end else if (setup_cnt != SETUP_MAX) begin
      setup_cnt <= setup_cnt + 1'b1;
    end
  end

  assign start_rise_o = start_i & ~start_q;
  assign cclk_fall_o  = cclk_q & ~cclk_i;
  assign fall_ok_o    = cclk_fall_o & track_i & (setup_cnt == SETUP_MAX);

  // R3: a counted edge never lands in the first tracking cycle
  a_r3_setup_window: assert property (@(posedge clk) disable iff (!rst_n)
    (track_i && setup_cnt == '0 && SETUP_CYCLES > 0) |-> !fall_ok_o);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             cmp_ge_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             last_o
);

  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sar_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] decided;

  always_comb begin
    decided = cmp_ge_i ? sar_q : (sar_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      sar_q  <= MSB_ONLY;
      mask_q <= MSB_ONLY;
    end else if (step_i) begin
      sar_q  <= decided | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  assign trial_o = sar_q;
  assign last_o  = mask_q[0];

  // R5: exactly one bit under trial at a time
  a_r5_one_bit_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));

  // R5: the trial code moves only on a decision, a load or a clear
  a_r5_trial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i || step_i || clr_i) |=> $stable(sar_q));

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clr_done_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);

  logic [WIDTH-1:0] res_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (load_i) begin
        res_q  <= data_i;
        done_q <= 1'b1;
      end else if (clr_done_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;

  // R9: the latch changes only on a transfer
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(res_q));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int HOLD_EDGES   = 4,
  parameter int SETUP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cclk_i,
  input  logic             cmp_ge_i,
  output logic             hold_o,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  localparam int EW = $clog2(HOLD_EDGES + 1);
  localparam logic [EW-1:0] LAST_TRACK_EDGE = EW'(HOLD_EDGES - 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  seq_state_t    state_q;
  logic [EW-1:0] edge_cnt;
  logic          hold_q;
  logic          start_rise;
  logic          cclk_fall;
  logic          fall_ok;
  logic          accept;
  logic          load_msb;
  logic          step;
  logic          xfer;
  logic          last_bit;
  logic [WIDTH-1:0] trial;

  sar_edge_qual #(.SETUP_CYCLES(SETUP_CYCLES)) u_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cclk_i       (cclk_i),
    .track_i      (state_q == SEQ_TRACK),
    .start_rise_o (start_rise),
    .cclk_fall_o  (cclk_fall),
    .fall_ok_o    (fall_ok)
  );

  assign accept   = start_rise && (state_q == SEQ_IDLE);
  assign load_msb = fall_ok && (edge_cnt == LAST_TRACK_EDGE);
  assign step     = cclk_fall && (state_q == SEQ_CONV);
  assign xfer     = (state_q == SEQ_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      edge_cnt <= '0;
      hold_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q  <= SEQ_TRACK;
            edge_cnt <= '0;
          end
        end
        SEQ_TRACK: begin
          if (fall_ok) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (load_msb) begin
              state_q <= SEQ_CONV;
              hold_q  <= 1'b1;
            end
          end
        end
        SEQ_CONV: begin
          if (step && last_bit) state_q <= SEQ_XFER;
        end
        SEQ_XFER: begin
          state_q <= SEQ_IDLE;
          hold_q  <= 1'b0;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  sar_bit_engine #(.WIDTH(WIDTH)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_msb),
    .step_i   (step),
    .clr_i    (xfer),
    .cmp_ge_i (cmp_ge_i),
    .trial_o  (trial),
    .last_o   (last_bit)
  );

  sar_out_latch #(.WIDTH(WIDTH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (xfer),
    .clr_done_i (accept),
    .data_i     (trial),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  assign hold_o  = hold_q;
  assign trial_o = trial;
  assign busy_o  = (state_q != SEQ_IDLE);

  // R4: hold starts with only the MSB under trial
  a_r4_hold_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (trial_o == MSB_ONLY));

  // R6: the end of a conversion leaves done set and the search register clear
  a_r6_transfer_state: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && !hold_o && trial_o == '0));

  // R8: a running conversion is never cut short or restarted
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_TRACK || state_q == SEQ_CONV) |=> busy_o);

  // R2: done is low for the whole of a conversion
  a_r2_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_TRACK || state_q == SEQ_CONV) |-> !done_o);

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

  localparam int W = 8;
  localparam int SETUP = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         cclk_i = 1'b1;
  logic         cmp_ge_i;
  logic         hold_o;
  logic [W-1:0] trial_o;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] result_o;

  logic [W-1:0] stim = '0;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cdiv   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sar_conv_seq i_sar_conv_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cclk_i   (cclk_i),
    .cmp_ge_i (cmp_ge_i),
    .hold_o   (hold_o),
    .trial_o  (trial_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  // ideal comparator against the stimulus code
  assign cmp_ge_i = (stim >= trial_o);

  always @(posedge clk) cyc++;

  // conversion clock: ten system cycles, high half then low half
  always @(posedge clk) begin
    #2;
    cdiv = (cdiv + 1) % 10;
    cclk_i = (cdiv < 5);
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_phase;     // 0 idle, 1 tracking, 2 searching, 3 handing over
  int  m_wait;
  int  m_edges;
  int  m_bitpos;
  int  m_trial;
  int  m_result;
  bit  m_done;
  bit  m_hold;
  bit  p_start;
  bit  p_cclk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_edges = 0; m_bitpos = 0;
      m_trial = 0; m_result = 0; m_done = 0; m_hold = 0;
      p_start = 0; p_cclk = 0;
    end else begin
      bit rise, fall;
      rise = start_i && !p_start;
      fall = p_cclk && !cclk_i;
      if (m_phase == 0) begin
        if (rise) begin
          m_phase = 1; m_wait = 0; m_edges = 0; m_done = 0;
        end
      end else if (m_phase == 1) begin
        if (fall && m_wait >= SETUP) begin
          m_edges++;
          if (m_edges == 4) begin
            m_phase = 2; m_hold = 1; m_trial = 128; m_bitpos = 7;
          end
        end
        m_wait++;
      end else if (m_phase == 2) begin
        if (fall) begin
          if (!(int'(stim) >= m_trial)) m_trial -= (1 << m_bitpos);
          if (m_bitpos == 0) m_phase = 3;
          else begin
            m_bitpos--;
            m_trial += (1 << m_bitpos);
          end
        end
      end else begin
        m_result = m_trial; m_done = 1; m_trial = 0; m_hold = 0; m_phase = 0;
      end
      p_start = start_i;
      p_cclk  = cclk_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5 trial vs model", int'(trial_o), m_trial);
      check("R4 hold vs model", int'(hold_o), int'(m_hold));
      check("R2 busy vs model", int'(busy_o), int'(m_phase != 0));
      check("R6 done vs model", int'(done_o), int'(m_done));
      check("R9 result vs model", int'(result_o), m_result);
    end
  end

  // start a conversion at a chosen conversion-clock phase; returns latency
  task automatic convert(input logic [W-1:0] code, input int phase,
                         input bit poke_busy, output int lat);
    int s;
    stim = code;
    forever begin
      @(posedge clk); #3;
      if (cdiv == phase) break;
    end
    start_i = 1'b1;
    s = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    repeat (2) @(posedge clk);
    #3 start_i = 1'b0;
    if (poke_busy) begin
      repeat (30) @(posedge clk);
      #3 start_i = 1'b1;
      repeat (3) @(posedge clk);
      #3 start_i = 1'b0;
    end
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_o) begin
        lat = cyc - s;
        break;
      end
    end
  endtask

  initial begin
    int lat_b, lat_a, lat;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R1 hold after reset", int'(hold_o), 0);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 trial after reset", int'(trial_o), 0);
    check("R1 result after reset", int'(result_o), 0);

    // phase 3: first falling edge sampled two edges after acceptance
    convert(8'h80, 3, 1'b0, lat_b);
    check("R10 latency qualifying phase", lat_b, 113);
    check("R7 midpoint code", int'(result_o), 8'h80);
    check("R6 trial cleared after transfer", int'(trial_o), 0);
    check("R6 hold low after transfer", int'(hold_o), 0);
    check("R6 busy low after transfer", int'(busy_o), 0);

    convert(8'h00, 3, 1'b0, lat);
    check("R7 lowest code", int'(result_o), 8'h00);
    check("R10 latency repeat", lat, 113);

    convert(8'hFF, 3, 1'b0, lat);
    check("R7 highest code", int'(result_o), 8'hFF);

    // phase 4: first falling edge too close, so it is skipped
    convert(8'h5A, 4, 1'b0, lat_a);
    check("R3 result with skipped edge", int'(result_o), 8'h5A);
    check("R3 latency with skipped edge", lat_a, 122);
    check("R3 latency difference", lat_a - lat_b, 9);

    convert(8'h33, 3, 1'b0, lat);
    check("R10 latency fixed phase", lat, 113);
    check("R5 search result 33h", int'(result_o), 8'h33);

    // start pulses while busy are ignored; previous result held meanwhile
    fork
      convert(8'hC4, 3, 1'b1, lat);
      begin
        repeat (60) @(negedge clk);
        check("R9 old result held mid-conversion", int'(result_o), 8'h33);
        check("R2 done low mid-conversion", int'(done_o), 0);
        check("R4 hold high mid-conversion", int'(hold_o), 1);
      end
    join
    check("R8 latency unaffected by busy start", lat, 113);
    check("R8 result unaffected by busy start", int'(result_o), 8'hC4);

    repeat (20) @(negedge clk);
    check("R8 no conversion from busy start", int'(busy_o), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule